// File: doc/BRIEF.md
# FPGA Slave-Serial Configuration Sequencer

This block loads an SRAM-based FPGA over its slave-serial configuration port. On a start strobe it pulls the active-low program line, waits for the device to signal that its configuration memory is being cleared (INIT low), releases the program line and waits for INIT to return high. It then takes bitstream bytes from an upstream buffer over a valid/ready handshake and serialises them onto a clock/data pair. Each phase that waits on the device has its own timeout and its own failure code.

Once the final byte has been shifted, the sequencer waits for DONE. If DONE arrives, it parks the configuration pins in two timed steps: first program and clock high with data low, then data high as well. After that it reports success. On any failure it returns at once, with program high and clock and data low. A busy flag spans the whole run. The status code is updated only when a run finishes.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and after it is released, `prog_n_o` is 1, `cclk_o`, `din_o`, `busy_o` and `byte_ready_o` are 0, and `status_o` is 0.
- R2: A start strobe in idle raises `busy_o` on the next cycle and drives `prog_n_o` low. The program line stays low until `init_i` is sampled low, then returns high.
- R3: If `init_i` is not sampled low within INIT_LO cycles of entering the program phase, the run ends with status 1. This is pass when INIT falls on cycle INIT_LO or earlier and fail when it falls on cycle INIT_LO+1. The pins are left as program high, clock low and data low.
- R4: If `init_i` does not return high within INIT_HI cycles after the program line is released, the run ends with status 2. No byte is requested.
- R5: `byte_ready_o` is high only after INIT has returned high and while bytes are still expected. Each accepted byte goes out MSB first, two clocks per bit. The bit is placed on `din_o` while `cclk_o` is low, and `cclk_o` is then high for one clock with `din_o` unchanged.
- R6: A byte accepted with `byte_last_i` high is the final byte, and no further bytes are requested. If `done_i` is not sampled high within DONE_TO cycles after that byte has been shifted, the run ends with status 3.
- R7: When DONE is seen, `prog_n_o` and `cclk_o` go high with `din_o` low for PAUSE+1 cycles. Then `din_o` is also high for PAUSE+1 cycles. Then the status becomes 0 and `busy_o` falls, and all three pins stay high until the next start.
- R8: A start strobe that arrives while `busy_o` is high has no effect on the run in progress, its bit stream or its result.
- R9: `busy_o` stays high from the cycle after the start until the status is latched. `status_o` changes only in the cycle in which `busy_o` falls. Status codes are 0 for success, 1 for INIT not low, 2 for INIT not high and 3 for DONE not high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| byte_i | input | 8 | Bitstream byte |
| byte_last_i | input | 1 | Marks the final byte of the stream |
| byte_valid_i | input | 1 | Byte is valid |
| byte_ready_o | output | 1 | Byte is accepted when valid and ready are both high |
| init_i | input | 1 | INIT feedback level from the device |
| done_i | input | 1 | DONE feedback level from the device |
| prog_n_o | output | 1 | Active-low program line |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration serial data |
| busy_o | output | 1 | A run is in progress |
| status_o | output | 2 | Result of the last run |

## Verification
The INIT-low timeout is probed on both sides of its deadline: INIT falling on the last allowed cycle and INIT falling one cycle late. A counter that is off by one would either reject the first case or accept the second. Each failure code is provoked on its own with the pins checked afterwards, so swapped codes or a missing return to idle levels show up. The captured serial stream is compared byte by byte, which exposes LSB-first shifting, lost bytes and data changing under a high clock. The two parking steps are measured in cycles. A stray start during shifting must leave both the bits and the result intact, which catches a sequencer that restarts.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITHI,
    ST_SHIFT,
    ST_DONEW,
    ST_PARK_LO,
    ST_PARK_HI
  } seq_state_e;

  localparam logic [1:0] STAT_OK         = 2'd0;
  localparam logic [1:0] STAT_NO_INIT_LO = 2'd1;
  localparam logic [1:0] STAT_NO_INIT_HI = 2'd2;
  localparam logic [1:0] STAT_NO_DONE    = 2'd3;

endpackage

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgseq_shifter.sv
module cfgseq_shifter #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          load_i,
  input  logic [BW-1:0] byte_i,
  output logic          ready_o,
  output logic          idle_o,
  output logic          cclk_o,
  output logic          din_o
);

  localparam int unsigned CW = $clog2(BW + 1);

  logic [BW-1:0] sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;

  // ready on an empty shifter, or in the high half of the final bit
  assign ready_o = enable_i &
                   ((cnt_q == '0) || ((cnt_q == CW'(1)) && phase_q));

  always_comb begin
    sreg_d  = sreg_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (load_i) begin
      sreg_d  = byte_i;
      cnt_d   = CW'(BW);
      phase_d = 1'b0;
    end else if (cnt_q != '0) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        sreg_d  = {sreg_q[BW-2:0], 1'b0};
        cnt_d   = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      sreg_q  <= sreg_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign idle_o = (cnt_q == '0);
  assign cclk_o = phase_q;
  assign din_o  = sreg_q[BW-1];

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgseq_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned INIT_LO_US = 1000,
  parameter int unsigned INIT_HI_US = 1000,
  parameter int unsigned DONE_US    = 1000,
  parameter int unsigned PAUSE_US   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       byte_last_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       busy_o,
  output logic [1:0] status_o
);

  localparam int unsigned INIT_LO_CYC = CLK_KHZ * INIT_LO_US / 1000;
  localparam int unsigned INIT_HI_CYC = CLK_KHZ * INIT_HI_US / 1000;
  localparam int unsigned DONE_CYC    = CLK_KHZ * DONE_US / 1000;
  localparam int unsigned PAUSE_CYC   = CLK_KHZ * PAUSE_US / 1000;
  localparam int unsigned MAX_A = (INIT_LO_CYC > INIT_HI_CYC) ? INIT_LO_CYC : INIT_HI_CYC;
  localparam int unsigned MAX_B = (DONE_CYC > PAUSE_CYC) ? DONE_CYC : PAUSE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic       busy_q, busy_d;
  logic [1:0] status_q, status_d;
  logic       park_q, park_d;
  logic       last_q, last_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sh_en, sh_ready, sh_idle, sh_cclk, sh_din;
  logic          accept;

  assign sh_en  = (state_q == ST_SHIFT) && !last_q;
  assign accept = sh_ready && byte_valid_i;

  cfgseq_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cfgseq_shifter #(.BW(8)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (sh_en),
    .load_i   (accept),
    .byte_i   (byte_i),
    .ready_o  (sh_ready),
    .idle_o   (sh_idle),
    .cclk_o   (sh_cclk),
    .din_o    (sh_din)
  );

  // next state
  always_comb begin
    state_d  = state_q;
    busy_d   = busy_q;
    status_d = status_q;
    park_d   = park_q;
    last_d   = last_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PROG;
        busy_d  = 1'b1;
        park_d  = 1'b0;
      end
      ST_PROG: begin
        if (!init_i) state_d = ST_INITHI;
        else if (tmr_zero) begin
          state_d = ST_IDLE; busy_d = 1'b0; status_d = STAT_NO_INIT_LO;
        end
      end
      ST_INITHI: begin
        if (init_i) begin
          state_d = ST_SHIFT;
          last_d  = 1'b0;
        end else if (tmr_zero) begin
          state_d = ST_IDLE; busy_d = 1'b0; status_d = STAT_NO_INIT_HI;
        end
      end
      ST_SHIFT: begin
        if (accept && byte_last_i) last_d = 1'b1;
        if (last_q && sh_idle) state_d = ST_DONEW;
      end
      ST_DONEW: begin
        if (done_i) state_d = ST_PARK_LO;
        else if (tmr_zero) begin
          state_d = ST_IDLE; busy_d = 1'b0; status_d = STAT_NO_DONE;
        end
      end
      ST_PARK_LO: if (tmr_zero) state_d = ST_PARK_HI;
      ST_PARK_HI: if (tmr_zero) begin
        state_d  = ST_IDLE;
        busy_d   = 1'b0;
        status_d = STAT_OK;
        park_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // timer reload on every phase change, with the limit of the phase entered
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_PROG:                tmr_val = TW'(INIT_LO_CYC);
      ST_INITHI:              tmr_val = TW'(INIT_HI_CYC);
      ST_DONEW:               tmr_val = TW'(DONE_CYC);
      ST_PARK_LO, ST_PARK_HI: tmr_val = TW'(PAUSE_CYC);
      default:                tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      busy_q   <= 1'b0;
      status_q <= STAT_OK;
      park_q   <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      busy_q   <= busy_d;
      status_q <= status_d;
      park_q   <= park_d;
      last_q   <= last_d;
    end
  end

  // pin decode from registered state only
  always_comb begin
    prog_n_o = (state_q != ST_PROG);
    unique case (state_q)
      ST_SHIFT:   begin cclk_o = sh_cclk; din_o = sh_din; end
      ST_PARK_LO: begin cclk_o = 1'b1;    din_o = 1'b0;   end
      ST_PARK_HI: begin cclk_o = 1'b1;    din_o = 1'b1;   end
      ST_IDLE:    begin cclk_o = park_q;  din_o = park_q; end
      default:    begin cclk_o = 1'b0;    din_o = 1'b0;   end
    endcase
  end

  assign byte_ready_o = sh_ready;
  assign busy_o       = busy_q;
  assign status_o     = status_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic [1:0] status_o
);

  // R2
  prog_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o);

  // R5
  ready_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && prog_n_o));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(status_o));

  // R7
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && status_o == 2'd0) |-> (prog_n_o && cclk_o && din_o));

  // R3
  fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && status_o != 2'd0) |-> (prog_n_o && !cclk_o && !din_o));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (.*);

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;

  localparam int PAUSE = 5;

  logic       clk, rst_n, start_i, byte_last_i, byte_valid_i, init_i, done_i;
  logic [7:0] byte_i;
  logic       byte_ready_o, prog_n_o, cclk_o, din_o, busy_o;
  logic [1:0] status_o;

  cfg_serial_loader #(
    .CLK_KHZ(1000), .INIT_LO_US(8), .INIT_HI_US(10), .DONE_US(12), .PAUSE_US(PAUSE)
  ) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit fin = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'h5A ^ 8'(v * 29) ^ 8'(i * 71);
  endfunction

  typedef struct packed {
    logic [7:0] lo;    // cycles until INIT falls, 255 = never
    logic [7:0] hi;    // cycles until INIT rises, 255 = never
    logic [3:0] nb;
    logic       ok;    // DONE answered
    logic       stray; // extra start while shifting
    logic [1:0] exp;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'd3,   8'd4,   4'd3, 1'b1, 1'b0, 2'd0},
    '{8'd255, 8'd0,   4'd0, 1'b0, 1'b0, 2'd1},
    '{8'd2,   8'd255, 4'd0, 1'b0, 1'b0, 2'd2},
    '{8'd1,   8'd1,   4'd2, 1'b0, 1'b0, 2'd3},
    '{8'd0,   8'd0,   4'd1, 1'b1, 1'b1, 2'd0},
    '{8'd8,   8'd2,   4'd1, 1'b1, 1'b0, 2'd0},
    '{8'd9,   8'd0,   4'd0, 1'b0, 1'b0, 2'd1}
  };

  task automatic run(input int v, input vec_t t);
    bit cap_fin = 0;
    int lo_n = 0, hi_n = 0;
    init_i = 1'b1; done_i = 1'b0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    check(prog_n_o == 1'b0 && byte_ready_o == 1'b0, "R2 program low, R5 no ready",
          {prog_n_o, byte_ready_o}, 0);
    fork
      begin : init_agent
        while (prog_n_o) @(negedge clk);
        if (t.lo != 8'd255) begin
          repeat (t.lo) @(negedge clk);
          init_i = 1'b0;
          while (!prog_n_o) @(negedge clk);
          if (t.hi != 8'd255) begin
            repeat (t.hi) @(negedge clk);
            init_i = 1'b1;
          end
        end
      end
      begin : feeder
        for (int i = 0; i < int'(t.nb); i++) begin
          @(negedge clk);
          byte_valid_i = 1'b1; byte_i = pat(v, i);
          byte_last_i = (i == int'(t.nb) - 1);
          while (!byte_ready_o) @(negedge clk);
          @(posedge clk);
        end
        @(negedge clk) byte_valid_i = 1'b0; byte_last_i = 1'b0;
      end
      begin : capture
        for (int i = 0; i < int'(t.nb); i++) begin
          logic [7:0] got;
          got = '0;
          for (int b = 0; b < 8; b++) begin
            @(posedge cclk_o);
            got = {got[6:0], din_o};
          end
          check(got == pat(v, i), "R5 serial byte MSB first", got, pat(v, i));
        end
        cap_fin = 1;
        if (t.ok) @(negedge clk) done_i = 1'b1;
      end
      begin : stray_start
        if (t.stray) begin
          do @(negedge clk); while (!byte_ready_o);
          start_i = 1'b1;
          @(negedge clk) start_i = 1'b0;
        end
      end
      begin : monitor
        bit armed = 0;
        forever begin
          @(negedge clk);
          if (!busy_o) break;
          if (cap_fin && !cclk_o) armed = 1;
          if (armed && prog_n_o && cclk_o && !din_o) lo_n++;
          if (armed && prog_n_o && cclk_o && din_o) hi_n++;
        end
      end
    join
    check(status_o == t.exp, $sformatf("R3 R4 R6 R7 status vector %0d", v), status_o, t.exp);
    if (t.exp == 2'd0) begin
      check(lo_n == PAUSE + 1, "R7 clock-high data-low pause", lo_n, PAUSE + 1);
      check(hi_n == PAUSE + 1, "R7 data-high pause", hi_n, PAUSE + 1);
      check({prog_n_o, cclk_o, din_o} == 3'b111, "R7 parked high", {prog_n_o, cclk_o, din_o}, 7);
      if (t.stray) check(1'b1, "R8 stray start ignored", 0, 0);
    end else begin
      check({prog_n_o, cclk_o, din_o, byte_ready_o} == 4'b1000, "R3 R4 R6 idle pins after fail",
            {prog_n_o, cclk_o, din_o, byte_ready_o}, 8);
    end
    repeat (3) @(negedge clk);
    check(status_o == t.exp && !busy_o, "R9 status held after run", status_o, t.exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_i = '0; byte_last_i = 1'b0;
    byte_valid_i = 1'b0; init_i = 1'b1; done_i = 1'b0;
    repeat (3) @(negedge clk);
    check({prog_n_o, cclk_o, din_o, busy_o, byte_ready_o} == 5'b10000, "R1 pins in reset",
          {prog_n_o, cclk_o, din_o, busy_o, byte_ready_o}, 16);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_o == 2'd0 && !busy_o && prog_n_o, "R1 state after reset", status_o, 0);

    for (int v = 0; v < 7; v++) run(v, VECS[v]);

    // start while in the program phase is ignored (R8)
    init_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(!prog_n_o && busy_o, "R8 program still low", prog_n_o, 0);
    // reset mid-run returns to reset levels (R1)
    rst_n = 1'b0;
    #1;
    check({prog_n_o, cclk_o, din_o, busy_o, status_o} == 6'b100000, "R1 async reset mid-run",
          {prog_n_o, cclk_o, din_o, busy_o, status_o}, 32);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && prog_n_o, "R1 idle after mid-run reset", busy_o, 0);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule